// File: doc/BRIEF.md
# Host-to-Controller Doorbell Mailbox

The block is a two-way mailbox that sits between a host processor and an embedded controller. It keeps two rings of 32-bit slots. The transmit ring carries words from the host to the controller, and the receive ring carries words from the controller to the host. The host reaches the block through a small register window of four word addresses:

| Address | Host write | Host read |
|---------|------------|-----------|
| 0 | pushes the word into the transmit ring | returns zero |
| 1 | has no effect | pops the head of the receive ring |
| 2 | updates the host control/status word | returns the host control/status word |
| 3 | has no effect | returns the controller control/status word |

The controller has a plain strobe port. With it the controller pushes into the receive ring, pops from the transmit ring, and writes its own control/status word.

Each status word reports several things about the ring it describes: the ring depth, its raw free-running 8-bit write pointer and its raw 8-bit read pointer. From these two pointers software works out the occupancy, which is the write pointer minus the read pointer taken modulo 256. The word also holds the control bits:
- a ready flag;
- an interrupt enable;
- a write-one-to-clear interrupt status;
- a doorbell bit, which raises the interrupt status of the other side.

Each side gets a level interrupt.

The reset handshake runs on a two-state link machine. The host writes its reset bit to 1 and then back to 0.
- State `LNK_RUN` is normal operation.
- The transition RUN→HOLD happens on a host status write with reset=1.
- In `LNK_HOLD`, both rings are empty with their pointers at zero, and both ready flags are forced low.
- The transition HOLD→RUN happens on a host status write with reset=0.
- After the block reset the machine is in `LNK_RUN`.

Top module: `hostlink_mailbox`

## Requirements
- R1: A status word holds the following fields. Bits 31:24 hold the ring depth (parameter DEPTH, default 32), which never changes. Bits 23:16 hold the write pointer and bits 15:8 the read pointer. Bit 4 is the reset bit (host word only; it reads 0 in the controller word). Bit 3 is ready, bit 2 is the doorbell (always reads 0), bit 1 is the interrupt status and bit 0 is the interrupt enable. Bits 7:5 read 0. After block reset both words read depth, then zero pointers, then zero control bits. The host word describes the transmit ring and the controller word describes the receive ring.
- R2: A host write to address 0 pushes one word into the transmit ring. A controller pop presents the oldest word on `ctl_pop_data` in the same cycle and removes it at the clock edge.
- R3: A controller push adds one word to the receive ring. A host read of address 1 returns the oldest word in the same cycle and removes it at the clock edge.
- R4: A push to a ring that already holds DEPTH words is dropped, and its write pointer does not move. This holds even when a pop happens in the same cycle. Occupancy never exceeds DEPTH.
- R5: A pop from an empty ring returns zero and leaves the read pointer unchanged.
- R6: The pointers are free-running 8-bit counters that wrap from 255 to 0. The slot used is the pointer modulo DEPTH, so DEPTH must be a power of two from 2 to 128. Occupancy is the write pointer minus the read pointer, modulo 256.
- R7: Writing a status word with bit 1 set clears that side's interrupt status. Writing it with bit 1 clear leaves the status unchanged. A set event in the same cycle wins over the clear.
- R8: Writing 1 to the doorbell bit (bit 2) of one side's word sets the interrupt status of the other side at that clock edge.
- R9: Any change of one side's ready bit sets the interrupt status of the other side at the same edge. This includes the change made by forcing it low in hold.
- R10: Each side's interrupt line equals its interrupt status ANDed with its interrupt enable.
- R11: A host status write with bit 4 = 1 enters hold at that edge. In hold, both rings' pointers are zero and both ready bits are zero. Pushes, pops and ready writes are ignored. A host status write with bit 4 = 0 leaves hold.
- R12: Host writes to address 1 or address 3 change nothing. A host read of address 0 returns zero and pops nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| hst_wr_en | input | 1 | host write strobe |
| hst_wr_addr | input | 2 | host write word address |
| hst_wr_data | input | 32 | host write data |
| hst_rd_en | input | 1 | host read strobe (pops at address 1) |
| hst_rd_addr | input | 2 | host read word address |
| hst_rd_data | output | 32 | host read data, combinational from the read address |
| hst_irq | output | 1 | host level interrupt |
| ctl_push | input | 1 | controller push into the receive ring |
| ctl_push_data | input | 32 | word pushed by the controller |
| ctl_pop | input | 1 | controller pop from the transmit ring |
| ctl_pop_data | output | 32 | head of the transmit ring, zero when empty |
| ctl_csr_wr | input | 1 | controller status write strobe |
| ctl_csr_wdata | input | 32 | controller status write data (bits 3:0 used) |
| ctl_csr_rdata | output | 32 | controller status word |
| ctl_peer_csr | output | 32 | host status word as seen by the controller |
| ctl_irq | output | 1 | controller level interrupt |

## Verification
The bench goes after several corner cases:
- **Full ring with a pop in the same cycle.** A design that judged fullness after the pop would accept a 33rd word, and the occupancy would exceed the depth.
- **Pointer wrap past 255.** A design that wrapped the pointers at the depth would report a huge false occupancy.
- **A doorbell colliding with a write-one-to-clear.** Here a wrong priority silently loses an interrupt.
- **Writes that leave the status bit at 0.** A design that wrote the bit straight through would drop pending interrupts.
- **Reset hold.** The bench checks that stale ring data vanishes, and that ready bits forced low raise the peer's interrupt.

The bench also reads the write-only and read-only windows the wrong way round. This shows that a stray decode neither pops a word nor changes state.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned BIT_IE  = 0;
    localparam int unsigned BIT_IS  = 1;
    localparam int unsigned BIT_IG  = 2;
    localparam int unsigned BIT_RDY = 3;
    localparam int unsigned BIT_RST = 4;

    localparam logic [1:0] ADDR_TXWIN = 2'd0;
    localparam logic [1:0] ADDR_RXWIN = 2'd1;
    localparam logic [1:0] ADDR_HSTAT = 2'd2;
    localparam logic [1:0] ADDR_CSTAT = 2'd3;

    typedef enum logic {
        LNK_RUN  = 1'b0,
        LNK_HOLD = 1'b1
    } link_state_t;

    typedef struct packed {
        logic ie;
        logic is;
        logic rdy;
    } side_bits_t;

    function automatic logic [31:0] pack_status(
        input logic [7:0] depth,
        input logic [7:0] wptr,
        input logic [7:0] rptr,
        input logic       rst,
        input side_bits_t bits
    );
        logic [31:0] w;
        w              = '0;
        w[31:24]       = depth;
        w[23:16]       = wptr;
        w[15:8]        = rptr;
        w[BIT_RST]     = rst;
        w[BIT_RDY]     = bits.rdy;
        w[BIT_IS]      = bits.is;
        w[BIT_IE]      = bits.ie;
        return w;
    endfunction

endpackage

// File: rtl/mbx_ring.sv
module mbx_ring #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic [7:0]       wr_ptr,
    output logic [7:0]       rd_ptr
);

    localparam int unsigned IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [7:0]  DEPTH_B = 8'(DEPTH);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [7:0]       occupancy;
    logic             is_full;
    logic             is_empty;
    logic             do_push;
    logic             do_pop;

    always_comb begin
        occupancy = wr_ptr - rd_ptr;
        is_full   = (occupancy == DEPTH_B);
        is_empty  = (occupancy == 8'd0);
        do_push   = push && !is_full && !clear;
        do_pop    = pop && !is_empty && !clear;
        head_data = is_empty ? '0 : slots[rd_ptr[IDX_W-1:0]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 8'd1;
            if (do_pop)  rd_ptr <= rd_ptr + 8'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) slots[wr_ptr[IDX_W-1:0]] <= push_data;
    end

endmodule

// File: rtl/mbx_side_csr.sv
module mbx_side_csr
    import mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic       wr,
    input  logic       wr_ie,
    input  logic       wr_is,
    input  logic       wr_ig,
    input  logic       wr_rdy,
    input  logic       peer_evt,
    output side_bits_t bits,
    output logic       ring_peer,
    output logic       rdy_flip
);

    side_bits_t bits_nxt;

    always_comb begin
        bits_nxt     = bits;
        bits_nxt.rdy = hold ? 1'b0 : (wr ? wr_rdy : bits.rdy);
        if (wr) bits_nxt.ie = wr_ie;
        if (peer_evt)
            bits_nxt.is = 1'b1;
        else if (wr && wr_is)
            bits_nxt.is = 1'b0;
        rdy_flip  = (bits_nxt.rdy != bits.rdy);
        ring_peer = wr && wr_ig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits <= '0;
        else        bits <= bits_nxt;
    end

endmodule

// File: rtl/mbx_link_fsm.sv
module mbx_link_fsm
    import mbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic        rst_req,
    output link_state_t state,
    output logic        hold_next
);

    link_state_t state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LNK_RUN;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            LNK_RUN:  if (ctrl_wr && rst_req)  state_nxt = LNK_HOLD;
            LNK_HOLD: if (ctrl_wr && !rst_req) state_nxt = LNK_RUN;
            default:  state_nxt = LNK_RUN;
        endcase
    end

    always_comb begin
        hold_next = (state_nxt == LNK_HOLD);
    end

endmodule

// File: rtl/hostlink_mailbox.sv
module hostlink_mailbox
    import mbx_pkg::*;
#(
    parameter int unsigned DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hst_wr_en,
    input  logic [1:0]  hst_wr_addr,
    input  logic [31:0] hst_wr_data,
    input  logic        hst_rd_en,
    input  logic [1:0]  hst_rd_addr,
    output logic [31:0] hst_rd_data,
    output logic        hst_irq,
    input  logic        ctl_push,
    input  logic [31:0] ctl_push_data,
    input  logic        ctl_pop,
    output logic [31:0] ctl_pop_data,
    input  logic        ctl_csr_wr,
    input  logic [31:0] ctl_csr_wdata,
    output logic [31:0] ctl_csr_rdata,
    output logic [31:0] ctl_peer_csr,
    output logic        ctl_irq
);

    localparam logic [7:0] DEPTH_FIELD = 8'(DEPTH);

    logic        hst_stat_wr;
    logic        tx_push;
    logic        rx_pop;
    logic        hold;
    link_state_t lnk_state;

    logic [31:0] rx_head;
    logic [7:0]  tx_wp, tx_rp, rx_wp, rx_rp;

    side_bits_t  h_bits, c_bits;
    logic        h_ring, h_flip, c_ring, c_flip;

    logic        unused_ctl_bits;

    always_comb begin
        hst_stat_wr = hst_wr_en && (hst_wr_addr == ADDR_HSTAT);
        tx_push     = hst_wr_en && (hst_wr_addr == ADDR_TXWIN);
        rx_pop      = hst_rd_en && (hst_rd_addr == ADDR_RXWIN);
    end

    assign unused_ctl_bits = ^ctl_csr_wdata[31:4];

    mbx_link_fsm u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (hst_stat_wr),
        .rst_req   (hst_wr_data[BIT_RST]),
        .state     (lnk_state),
        .hold_next (hold)
    );

    mbx_ring #(.DEPTH(DEPTH), .WIDTH(32)) u_tx_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (hold),
        .push      (tx_push),
        .push_data (hst_wr_data),
        .pop       (ctl_pop),
        .head_data (ctl_pop_data),
        .wr_ptr    (tx_wp),
        .rd_ptr    (tx_rp)
    );

    mbx_ring #(.DEPTH(DEPTH), .WIDTH(32)) u_rx_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (hold),
        .push      (ctl_push),
        .push_data (ctl_push_data),
        .pop       (rx_pop),
        .head_data (rx_head),
        .wr_ptr    (rx_wp),
        .rd_ptr    (rx_rp)
    );

    mbx_side_csr u_host_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .wr        (hst_stat_wr),
        .wr_ie     (hst_wr_data[BIT_IE]),
        .wr_is     (hst_wr_data[BIT_IS]),
        .wr_ig     (hst_wr_data[BIT_IG]),
        .wr_rdy    (hst_wr_data[BIT_RDY]),
        .peer_evt  (c_ring || c_flip),
        .bits      (h_bits),
        .ring_peer (h_ring),
        .rdy_flip  (h_flip)
    );

    mbx_side_csr u_ctl_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .wr        (ctl_csr_wr),
        .wr_ie     (ctl_csr_wdata[BIT_IE]),
        .wr_is     (ctl_csr_wdata[BIT_IS]),
        .wr_ig     (ctl_csr_wdata[BIT_IG]),
        .wr_rdy    (ctl_csr_wdata[BIT_RDY]),
        .peer_evt  (h_ring || h_flip),
        .bits      (c_bits),
        .ring_peer (c_ring),
        .rdy_flip  (c_flip)
    );

    always_comb begin
        ctl_peer_csr  = pack_status(DEPTH_FIELD, tx_wp, tx_rp,
                                    (lnk_state == LNK_HOLD), h_bits);
        ctl_csr_rdata = pack_status(DEPTH_FIELD, rx_wp, rx_rp, 1'b0, c_bits);
        hst_irq       = h_bits.is && h_bits.ie;
        ctl_irq       = c_bits.is && c_bits.ie;
    end

    always_comb begin
        unique case (hst_rd_addr)
            ADDR_TXWIN: hst_rd_data = '0;
            ADDR_RXWIN: hst_rd_data = rx_head;
            ADDR_HSTAT: hst_rd_data = ctl_peer_csr;
            ADDR_CSTAT: hst_rd_data = ctl_csr_rdata;
            default:    hst_rd_data = '0;
        endcase
    end

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
    parameter int unsigned DEPTH = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic        hst_stat_wr,
    input logic        wr_is_bit,
    input logic        hst_irq,
    input logic        ctl_irq,
    input logic        ctl_pop,
    input logic [31:0] ctl_csr_rdata,
    input logic [31:0] ctl_peer_csr
);

    localparam logic [7:0] DEPTH_B = 8'(DEPTH);

    logic [7:0] tx_occ;
    logic [7:0] rx_occ;
    assign tx_occ = ctl_peer_csr[23:16] - ctl_peer_csr[15:8];
    assign rx_occ = ctl_csr_rdata[23:16] - ctl_csr_rdata[15:8];

    assert_depth_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_peer_csr[31:24] == DEPTH_B && ctl_csr_rdata[31:24] == DEPTH_B);

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_peer_csr[7:5] == 3'b0 && ctl_csr_rdata[7:4] == 4'b0);

    assert_tx_occ_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_occ <= DEPTH_B);

    assert_rx_occ_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_occ <= DEPTH_B);

    assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_pop && tx_occ == 8'd0 && !hst_stat_wr) |=> $stable(ctl_peer_csr[15:8]));

    assert_w1c_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_stat_wr && !wr_is_bit && ctl_peer_csr[1]) |=> ctl_peer_csr[1]);

    assert_doorbell_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_peer_csr[2] && !ctl_csr_rdata[2]);

    assert_host_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hst_irq |-> (ctl_peer_csr[1] && ctl_peer_csr[0]));

    assert_ctl_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_irq |-> (ctl_csr_rdata[1] && ctl_csr_rdata[0]));

    assert_hold_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_peer_csr[4] |-> (ctl_peer_csr[23:8] == 16'd0 && ctl_csr_rdata[23:8] == 16'd0
                             && !ctl_peer_csr[3] && !ctl_csr_rdata[3]));

endmodule

bind hostlink_mailbox mbx_checker #(.DEPTH(DEPTH)) u_mbx_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .hst_stat_wr   (hst_wr_en && (hst_wr_addr == 2'd2)),
    .wr_is_bit     (hst_wr_data[1]),
    .hst_irq       (hst_irq),
    .ctl_irq       (ctl_irq),
    .ctl_pop       (ctl_pop),
    .ctl_csr_rdata (ctl_csr_rdata),
    .ctl_peer_csr  (ctl_peer_csr)
);

// File: tb/hostlink_mailbox_bench.sv
module hostlink_mailbox_bench;

    localparam int CLK_PERIOD = 10;
    localparam int D = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_wr_en;
    logic [1:0]  hst_wr_addr;
    logic [31:0] hst_wr_data;
    logic        hst_rd_en;
    logic [1:0]  hst_rd_addr;
    logic [31:0] hst_rd_data;
    logic        hst_irq;
    logic        ctl_push;
    logic [31:0] ctl_push_data;
    logic        ctl_pop;
    logic [31:0] ctl_pop_data;
    logic        ctl_csr_wr;
    logic [31:0] ctl_csr_wdata;
    logic [31:0] ctl_csr_rdata;
    logic [31:0] ctl_peer_csr;
    logic        ctl_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    hostlink_mailbox #(.DEPTH(D)) u_hostlink_mailbox (
        .clk(clk), .rst_n(rst_n),
        .hst_wr_en(hst_wr_en), .hst_wr_addr(hst_wr_addr), .hst_wr_data(hst_wr_data),
        .hst_rd_en(hst_rd_en), .hst_rd_addr(hst_rd_addr), .hst_rd_data(hst_rd_data),
        .hst_irq(hst_irq),
        .ctl_push(ctl_push), .ctl_push_data(ctl_push_data),
        .ctl_pop(ctl_pop), .ctl_pop_data(ctl_pop_data),
        .ctl_csr_wr(ctl_csr_wr), .ctl_csr_wdata(ctl_csr_wdata),
        .ctl_csr_rdata(ctl_csr_rdata), .ctl_peer_csr(ctl_peer_csr),
        .ctl_irq(ctl_irq)
    );

    // behavioural reference state
    logic [31:0] txq[$];
    logic [31:0] rxq[$];
    int tx_wp, tx_rp, rx_wp, rx_rp;
    bit h_ie, h_is, h_rdy, c_ie, c_is, c_rdy, hold;

    int checks = 0;
    int failures = 0;
    string phase = "R1";
    bit done = 1'b0;

    function automatic logic [31:0] word(int wp, int rp, bit rst, bit rdy, bit is, bit ie);
        return {8'(D), 8'(wp), 8'(rp), 3'b000, rst, rdy, 1'b0, is, ie};
    endfunction

    task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", phase, what, got, exp);
        end
    endtask

    task automatic compare();
        logic [31:0] exp_rd;
        case (hst_rd_addr)
            2'd0:    exp_rd = 32'd0;
            2'd1:    exp_rd = (rxq.size() > 0) ? rxq[0] : 32'd0;
            2'd2:    exp_rd = word(tx_wp, tx_rp, hold, h_rdy, h_is, h_ie);
            default: exp_rd = word(rx_wp, rx_rp, 1'b0, c_rdy, c_is, c_ie);
        endcase
        chk("hst_rd_data", hst_rd_data, exp_rd);
        chk("ctl_pop_data", ctl_pop_data, (txq.size() > 0) ? txq[0] : 32'd0);
        chk("ctl_peer_csr", ctl_peer_csr, word(tx_wp, tx_rp, hold, h_rdy, h_is, h_ie));
        chk("ctl_csr_rdata", ctl_csr_rdata, word(rx_wp, rx_rp, 1'b0, c_rdy, c_is, c_ie));
        chk("hst_irq", {31'd0, hst_irq}, {31'd0, h_is & h_ie});
        chk("ctl_irq", {31'd0, ctl_irq}, {31'd0, c_is & c_ie});
    endtask

    task automatic model_edge();
        bit hs = hst_wr_en && hst_wr_addr == 2'd2;
        bit cw = ctl_csr_wr;
        bit hold_n = hs ? hst_wr_data[4] : hold;
        bit h_rdy_n = hold_n ? 1'b0 : (hs ? hst_wr_data[3] : h_rdy);
        bit c_rdy_n = hold_n ? 1'b0 : (cw ? ctl_csr_wdata[3] : c_rdy);
        bit h_set = (cw && ctl_csr_wdata[2]) || (c_rdy_n != c_rdy);
        bit c_set = (hs && hst_wr_data[2]) || (h_rdy_n != h_rdy);
        bit tx_push_ok = hst_wr_en && hst_wr_addr == 2'd0 && txq.size() < D;
        bit tx_pop_ok = ctl_pop && txq.size() > 0;
        bit rx_push_ok = ctl_push && rxq.size() < D;
        bit rx_pop_ok = hst_rd_en && hst_rd_addr == 2'd1 && rxq.size() > 0;
        if (h_set) h_is = 1'b1; else if (hs && hst_wr_data[1]) h_is = 1'b0;
        if (c_set) c_is = 1'b1; else if (cw && ctl_csr_wdata[1]) c_is = 1'b0;
        if (hs) h_ie = hst_wr_data[0];
        if (cw) c_ie = ctl_csr_wdata[0];
        h_rdy = h_rdy_n;
        c_rdy = c_rdy_n;
        hold = hold_n;
        if (hold_n) begin
            txq.delete(); rxq.delete();
            tx_wp = 0; tx_rp = 0; rx_wp = 0; rx_rp = 0;
        end else begin
            if (tx_pop_ok) begin void'(txq.pop_front()); tx_rp = (tx_rp + 1) % 256; end
            if (tx_push_ok) begin txq.push_back(hst_wr_data); tx_wp = (tx_wp + 1) % 256; end
            if (rx_pop_ok) begin void'(rxq.pop_front()); rx_rp = (rx_rp + 1) % 256; end
            if (rx_push_ok) begin rxq.push_back(ctl_push_data); rx_wp = (rx_wp + 1) % 256; end
        end
    endtask

    task automatic idle();
        hst_wr_en = 0; hst_wr_addr = 0; hst_wr_data = 0;
        hst_rd_en = 0; hst_rd_addr = 2'd2;
        ctl_push = 0; ctl_push_data = 0; ctl_pop = 0;
        ctl_csr_wr = 0; ctl_csr_wdata = 0;
    endtask

    task automatic step();
        #1 compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        idle();
    endtask

    task automatic hwrite(logic [1:0] a, logic [31:0] d);
        hst_wr_en = 1; hst_wr_addr = a; hst_wr_data = d; step();
    endtask
    task automatic hread(logic [1:0] a);
        hst_rd_en = 1; hst_rd_addr = a; step();
    endtask
    task automatic cpush(logic [31:0] d);
        ctl_push = 1; ctl_push_data = d; step();
    endtask
    task automatic cpop();
        ctl_pop = 1; step();
    endtask
    task automatic cstat(logic [31:0] d);
        ctl_csr_wr = 1; ctl_csr_wdata = d; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired in phase %s", phase);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle();
        tx_wp = 0; tx_rp = 0; rx_wp = 0; rx_rp = 0;
        {h_ie, h_is, h_rdy, c_ie, c_is, c_rdy, hold} = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        phase = "R1";    // reset words and layout
        step();
        hst_rd_addr = 2'd3; step();

        phase = "R2";    // host to controller order
        for (int i = 0; i < 5; i++) hwrite(2'd0, 32'hA000_0000 + i);
        for (int i = 0; i < 5; i++) cpop();

        phase = "R3";    // controller to host order
        for (int i = 0; i < 4; i++) cpush(32'hB100_0000 + i);
        for (int i = 0; i < 4; i++) hread(2'd1);

        phase = "R5";    // pops from empty rings
        hread(2'd1); hread(2'd1); cpop(); cpop();

        phase = "R4";    // fill past depth, drop with simultaneous pop
        for (int i = 0; i < D + 2; i++) hwrite(2'd0, 32'hC000_0000 + i);
        for (int i = 0; i < D + 2; i++) cpush(32'hD000_0000 + i);
        hst_wr_en = 1; hst_wr_addr = 2'd0; hst_wr_data = 32'hDEAD_0001; ctl_pop = 1; step();
        ctl_push = 1; ctl_push_data = 32'hDEAD_0002; hst_rd_en = 1; hst_rd_addr = 2'd1; step();
        for (int i = 0; i < D; i++) cpop();
        for (int i = 0; i < D; i++) hread(2'd1);

        phase = "R6";    // pointer wrap past 255
        for (int i = 0; i < 300; i++) begin
            hst_wr_en = 1; hst_wr_addr = 2'd0; hst_wr_data = 32'h6000_0000 + i;
            ctl_pop = 1; step();
        end
        cpop();
        for (int i = 0; i < 270; i++) begin
            ctl_push = 1; ctl_push_data = 32'h6100_0000 + i;
            hst_rd_en = 1; hst_rd_addr = (i % 2 == 0) ? 2'd1 : 2'd3; step();
        end

        phase = "R8";    // doorbells
        cstat(32'h4);
        hwrite(2'd2, 32'h4);
        cstat(32'h2);
        hst_rd_addr = 2'd3; step();

        phase = "R7";    // write-one-to-clear
        hwrite(2'd2, 32'h0);
        hwrite(2'd2, 32'h2);
        cstat(32'h4);
        hst_wr_en = 1; hst_wr_addr = 2'd2; hst_wr_data = 32'h2;
        ctl_csr_wr = 1; ctl_csr_wdata = 32'h4; step();
        hwrite(2'd2, 32'h2);

        phase = "R9";    // ready changes
        cstat(32'h8);
        hwrite(2'd2, 32'h2);
        hwrite(2'd2, 32'h8);
        cstat(32'h8 | 32'h2);
        cstat(32'h0);

        phase = "R10";   // interrupt lines
        hwrite(2'd2, 32'h8 | 32'h1);
        cstat(32'h4);
        cstat(32'h1);
        hwrite(2'd2, 32'h8 | 32'h2 | 32'h1);
        hwrite(2'd2, 32'h8);

        phase = "R11";   // reset hold
        for (int i = 0; i < 3; i++) hwrite(2'd0, 32'hE000_0000 + i);
        for (int i = 0; i < 3; i++) cpush(32'hE100_0000 + i);
        cstat(32'h8);
        hwrite(2'd2, 32'h10 | 32'h4 | 32'h1);
        hwrite(2'd0, 32'h1234_5678);
        cpush(32'h8765_4321);
        cstat(32'h8);
        hread(2'd1);
        cpop();
        hwrite(2'd2, 32'h10 | 32'h8);
        hwrite(2'd2, 32'h4 | 32'h1);
        hwrite(2'd2, 32'h8 | 32'h4 | 32'h1);
        cpush(32'hE200_0000);
        hst_rd_addr = 2'd3; step();

        phase = "R12";   // stray decodes
        hwrite(2'd1, 32'hFFFF_FFFF);
        hwrite(2'd3, 32'hFFFF_FFFF);
        hread(2'd0);
        hread(2'd1);
        hst_rd_addr = 2'd3; step();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule